// File: doc/BRIEF.md
# Dual-Page LCD Command Decoder

This block turns the command bytes of a serial graphic LCD controller into its control register state. A byte arrives with a strobe and a data/command flag; only bytes flagged as commands are decoded. A stored page bit picks one of two instruction pages, so the same opcode bits can mean different commands. Page 0 sets the display mode and loads the column and bank address pointers. Page 1 sets the temperature coefficient, the bias system and the 7-bit operating voltage value. The function-set command and the no-operation code are recognised on both pages.

The register values are held in flip-flops and drive the rest of the controller. Column and bank pointer loads are not stored here. The decoder raises a one-clock load pulse, with the pointer value, while the command byte is on its inputs, and the address counter takes the value from there. Voltage generation and pixel output lie outside the block.

Top module: `lcdcmd_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets power-down to 1 and sets vertical mode, page, display mode, temperature coefficient, bias and voltage value to 0, with `pump_on` at 0.
- R2: A byte is decoded only in a cycle where `cmd_valid` is 1 and `cmd_dc` is 0. With `cmd_valid` low, or `cmd_dc` high (a display data byte), no register changes and no load pulse is raised.
- R3: Byte 0x00 is a no-operation on both pages.
- R4: A byte of the form 00100PVH is decoded on both pages. It sets power-down from bit 2, vertical mode from bit 1 and the page bit from bit 0.
- R5: On page 0, a byte of the form 00001D0E sets `disp_mode` to {D,E} (bit 2, bit 0). The codes are: 00 blank, 10 normal, 01 all segments on, 11 inverse.
- R6: On page 0, a byte of the form 01000yyy raises `y_load` for exactly the cycle of the strobe, with `y_addr` equal to bits 2:0.
- R7: On page 0, a byte with bit 7 set raises `x_load` for exactly the cycle of the strobe, with `x_addr` equal to bits 6:0.
- R8: On page 1, a byte of the form 000001tt sets the temperature coefficient to bits 1:0.
- R9: On page 1, a byte of the form 00010bbb sets the bias system to bits 2:0.
- R10: On page 1, a byte with bit 7 set sets the voltage value to bits 6:0. `pump_on` is 1 exactly when the stored voltage value is nonzero.
- R11: A command byte that matches no pattern of the current page leaves every register unchanged and raises no load pulse. This includes a page-0 pattern received on page 1 and the reverse.
- R12: Register updates take effect at the clock edge that ends the strobe cycle and are visible on the outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Byte strobe, one cycle per byte |
| cmd_dc | input | 1 | 0 = command byte, 1 = display data byte |
| cmd_byte | input | 8 | Received byte |
| pwr_down | output | 1 | Power-down flag |
| vert_addr | output | 1 | Vertical addressing flag |
| ext_page | output | 1 | Current instruction page |
| disp_mode | output | 2 | Display mode {D,E} |
| temp_coef | output | 2 | Temperature coefficient select |
| bias_sel | output | 3 | Bias system select |
| vop_val | output | 7 | Operating voltage value |
| pump_on | output | 1 | Charge pump enable (voltage value nonzero) |
| x_load | output | 1 | Column pointer load pulse |
| x_addr | output | 7 | Column pointer value |
| y_load | output | 1 | Bank pointer load pulse |
| y_addr | output | 3 | Bank pointer value |

## Verification
Some properties are checked on every cycle:
- The reset values.
- That no register moves without a decoded command strobe.
- That page-1 registers change only while page 1 is selected, and page-0 registers only while page 0 is.
- That the two load pulses are never raised together, and `x_load` only appears on page 0.
- That `pump_on` tracks the stored voltage value.

Only the bench scenarios can show that each opcode lands in the right field with the right bit positions. The same applies to the page switch changing the meaning of one opcode (0x90 as a voltage value on page 1 and a column load on page 0), to reserved codes and data bytes being dropped, and to the pulse data being correct in the strobe cycle.

// File: rtl/lcdcmd_pkg.sv
package lcdcmd_pkg;

  localparam int CMD_W  = 8;
  localparam int DISP_W = 2;
  localparam int TC_W   = 2;
  localparam int BIAS_W = 3;
  localparam int VOP_W  = 7;
  localparam int XA_W   = 7;
  localparam int YA_W   = 3;

  typedef enum logic [3:0] {
    OP_RSVD,
    OP_NOP,
    OP_FSET,
    OP_DISP,
    OP_SETY,
    OP_SETX,
    OP_TEMP,
    OP_BIAS,
    OP_VOP
  } cmd_op_e;

  typedef struct packed {
    logic              pd;
    logic              vert;
    logic              page;
    logic [DISP_W-1:0] disp;
    logic [TC_W-1:0]   tc;
    logic [BIAS_W-1:0] bias;
    logic [VOP_W-1:0]  vop;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pd: 1'b1, vert: 1'b0, page: 1'b0,
                                   disp: '0, tc: '0, bias: '0, vop: '0};

endpackage

// File: rtl/lcdcmd_classify.sv
module lcdcmd_classify
  import lcdcmd_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_b,
  input  logic             page_i,
  output cmd_op_e          op_o
);

  localparam int HI = CMD_W - 1;

  always_comb begin
    op_o = OP_RSVD;
    if (cmd_b == '0) begin
      op_o = OP_NOP;
    end else if (cmd_b[HI:3] == 5'b00100) begin
      op_o = OP_FSET;
    end else if (!page_i) begin
      if (cmd_b[HI])                                 op_o = OP_SETX;
      else if (cmd_b[HI:3] == 5'b01000)              op_o = OP_SETY;
      else if (cmd_b[HI:3] == 5'b00001 && !cmd_b[1]) op_o = OP_DISP;
    end else begin
      if (cmd_b[HI])                                 op_o = OP_VOP;
      else if (cmd_b[HI:2] == 6'b000001)             op_o = OP_TEMP;
      else if (cmd_b[HI:3] == 5'b00010)              op_o = OP_BIAS;
    end
  end

endmodule

// File: rtl/lcdcmd_regfile.sv
module lcdcmd_regfile
  import lcdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  cmd_op_e          op,
  input  logic [CMD_W-1:0] cmd_b,
  output ctrl_t            q,
  output logic             pump_q
);

  ctrl_t nxt;

  always_comb begin
    nxt = q;
    if (en) begin
      case (op)
        OP_FSET: begin
          nxt.pd   = cmd_b[2];
          nxt.vert = cmd_b[1];
          nxt.page = cmd_b[0];
        end
        OP_DISP: nxt.disp = {cmd_b[2], cmd_b[0]};
        OP_TEMP: nxt.tc   = cmd_b[TC_W-1:0];
        OP_BIAS: nxt.bias = cmd_b[BIAS_W-1:0];
        OP_VOP:  nxt.vop  = cmd_b[VOP_W-1:0];
        default: nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= CTRL_RESET;
      pump_q <= 1'b0;
    end else begin
      q      <= nxt;
      pump_q <= (nxt.vop != '0);
    end
  end

  // R1: reset values
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (q.pd && !q.vert && !q.page && q.disp == '0 && q.tc == '0 &&
             q.bias == '0 && q.vop == '0 && !pump_q));

  // R2: no strobe, no change
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> $stable(q));

  // R10: voltage value moves only on page 1
  p_vop_page_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(q.vop)) |-> $past(q.page));

  // R5: display mode moves only on page 0
  p_disp_page_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(q.disp)) |-> !$past(q.page));

  // R10: pump flag follows the stored voltage value
  p_pump_track_r10: assert property (@(posedge clk) disable iff (rst)
    pump_q == (q.vop != '0));

endmodule

// File: rtl/lcdcmd_decoder.sv
module lcdcmd_decoder
  import lcdcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_dc,
  input  logic [CMD_W-1:0]  cmd_byte,
  output logic              pwr_down,
  output logic              vert_addr,
  output logic              ext_page,
  output logic [DISP_W-1:0] disp_mode,
  output logic [TC_W-1:0]   temp_coef,
  output logic [BIAS_W-1:0] bias_sel,
  output logic [VOP_W-1:0]  vop_val,
  output logic              pump_on,
  output logic              x_load,
  output logic [XA_W-1:0]   x_addr,
  output logic              y_load,
  output logic [YA_W-1:0]   y_addr
);

  cmd_op_e op;
  ctrl_t   st;
  logic    cmd_en;

  assign cmd_en = cmd_valid && !cmd_dc;

  lcdcmd_classify u_cls (
    .cmd_b  (cmd_byte),
    .page_i (st.page),
    .op_o   (op)
  );

  lcdcmd_regfile u_regs (
    .clk    (clk),
    .rst    (rst),
    .en     (cmd_en),
    .op     (op),
    .cmd_b  (cmd_byte),
    .q      (st),
    .pump_q (pump_on)
  );

  assign x_load = cmd_en && (op == OP_SETX);
  assign y_load = cmd_en && (op == OP_SETY);
  assign x_addr = cmd_byte[XA_W-1:0];
  assign y_addr = cmd_byte[YA_W-1:0];

  assign pwr_down  = st.pd;
  assign vert_addr = st.vert;
  assign ext_page  = st.page;
  assign disp_mode = st.disp;
  assign temp_coef = st.tc;
  assign bias_sel  = st.bias;
  assign vop_val   = st.vop;

  // R11: never two pointer loads at once
  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({x_load, y_load}));

  // R7: column load only on page 0 with a command strobe
  p_xload_page_r7: assert property (@(posedge clk) disable iff (rst)
    x_load |-> (!ext_page && cmd_valid && !cmd_dc));

  // R6: bank load only on page 0 with a command strobe
  p_yload_page_r6: assert property (@(posedge clk) disable iff (rst)
    y_load |-> (!ext_page && cmd_valid && !cmd_dc));

  // R2: a data byte never raises a load pulse
  p_data_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_dc |-> !(x_load || y_load));

endmodule

// File: tb/sim_lcdcmd_decoder.sv
module sim_lcdcmd_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_dc = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       pwr_down, vert_addr, ext_page, pump_on, x_load, y_load;
  logic [1:0] disp_mode, temp_coef;
  logic [2:0] bias_sel, y_addr;
  logic [6:0] vop_val, x_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lcdcmd_decoder u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_dc(cmd_dc),
    .cmd_byte(cmd_byte), .pwr_down(pwr_down), .vert_addr(vert_addr),
    .ext_page(ext_page), .disp_mode(disp_mode), .temp_coef(temp_coef),
    .bias_sel(bias_sel), .vop_val(vop_val), .pump_on(pump_on),
    .x_load(x_load), .x_addr(x_addr), .y_load(y_load), .y_addr(y_addr)
  );

  typedef struct {
    string     tag;
    bit        xl;
    bit [6:0]  xv;
    bit        yl;
    bit [2:0]  yv;
    bit        pd, v, h, pump;
    bit [1:0]  disp, tc;
    bit [2:0]  bias;
    bit [6:0]  vop;
  } item_t;

  item_t exp_q[$];
  item_t m;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m.pd = 1; m.v = 0; m.h = 0; m.disp = 0; m.tc = 0;
    m.bias = 0; m.vop = 0; m.pump = 0;
  endtask

  task automatic check_state(string tag, item_t e);
    chk(tag, "pwr_down", pwr_down, e.pd);
    chk(tag, "vert_addr", vert_addr, e.v);
    chk(tag, "ext_page", ext_page, e.h);
    chk(tag, "disp_mode", disp_mode, e.disp);
    chk(tag, "temp_coef", temp_coef, e.tc);
    chk(tag, "bias_sel", bias_sel, e.bias);
    chk(tag, "vop_val", vop_val, e.vop);
    chk(tag, "pump_on", pump_on, e.pump);
  endtask

  // driver: apply one byte, predict from the requirements, push expectation
  task automatic send(bit valid, bit dc, bit [7:0] b, string tag);
    item_t e;
    e = m;
    e.tag = tag;
    e.xl = 0; e.yl = 0; e.xv = b[6:0]; e.yv = b[2:0];
    if (valid && !dc && b != 8'h00) begin
      if (b[7:3] == 5'b00100) begin
        e.pd = b[2]; e.v = b[1]; e.h = b[0];
      end else if (!m.h) begin
        if (b[7]) e.xl = 1;
        else if (b[7:3] == 5'b01000) e.yl = 1;
        else if (b[7:3] == 5'b00001 && !b[1]) e.disp = {b[2], b[0]};
      end else begin
        if (b[7]) e.vop = b[6:0];
        else if (b[7:2] == 6'b000001) e.tc = b[1:0];
        else if (b[7:3] == 5'b00010) e.bias = b[2:0];
      end
    end
    e.pump = (e.vop != 0);
    @(negedge clk);
    cmd_valid = valid; cmd_dc = dc; cmd_byte = b;
    exp_q.push_back(e);
    m = e;
    @(negedge clk);
    cmd_valid = 0; cmd_dc = 0; cmd_byte = 8'h00;
    @(negedge clk);
  endtask

  // monitor: pulses in the strobe cycle, registers one cycle later
  initial begin
    item_t e;
    forever begin
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      #1;
      chk(e.tag, "x_load", x_load, e.xl);
      chk(e.tag, "y_load", y_load, e.yl);
      if (e.xl) chk(e.tag, "x_addr", x_addr, e.xv);
      if (e.yl) chk(e.tag, "y_addr", y_addr, e.yv);
      @(negedge clk);
      #1;
      check_state(e.tag, e);
    end
  end

  bit done = 0;

  initial begin
    fork
      begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check_state("R1 reset", m);

        send(1, 0, 8'h21, "R4 fset page1");
        send(1, 0, 8'h90, "R10 vop 0x10");
        send(1, 0, 8'h06, "R8 tc=2");
        send(1, 0, 8'h13, "R9 bias=3");
        send(1, 0, 8'h0C, "R11 page0 disp on page1");
        send(1, 0, 8'h42, "R11 sety on page1");
        send(1, 0, 8'h00, "R3 nop page1");
        send(1, 0, 8'h20, "R4 fset page0");
        send(1, 0, 8'h0C, "R5 normal");
        send(1, 0, 8'h0D, "R5 inverse");
        send(1, 0, 8'h09, "R5 all on");
        send(1, 0, 8'h0E, "R11 disp bit1 set");
        send(1, 0, 8'h04, "R11 tc code on page0");
        send(1, 0, 8'h42, "R6 y=2");
        send(1, 0, 8'h45, "R6 y=5");
        send(1, 0, 8'hB7, "R7 x=55");
        send(1, 0, 8'h90, "R7 x=16 same opcode page0");
        send(1, 0, 8'hD3, "R7 x=83");
        send(1, 1, 8'h21, "R2 data byte");
        send(1, 1, 8'hC1, "R2 data no xload");
        send(0, 0, 8'h21, "R2 valid low");
        send(1, 0, 8'h00, "R3 nop page0");
        send(1, 0, 8'h22, "R4 vertical");
        send(1, 0, 8'h25, "R4 pd page1");
        send(1, 0, 8'h80, "R10 vop zero pump off");
        send(1, 0, 8'hFF, "R10 vop max");
        send(1, 0, 8'h07, "R8 tc=3");
        send(1, 0, 8'h17, "R9 bias=7");
        send(1, 0, 8'h08, "R11 reserved page1");
        send(1, 0, 8'h24, "R12 fset pd");

        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
        #1;
        check_state("R1 reset mid run", m);
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
      end
    join_any
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule